// File: doc/BRIEF.md
# Activate Rate Limiter

This block sits between a memory controller's command scheduler and the command bus. It decides, cycle by cycle, whether a pending row activation may go out. The scheduler presents one activate request together with the target bank. The limiter answers in the same cycle with a grant, or it withholds the grant and the request stalls. Its timing history moves forward only on granted activations. A request that is stalled, or withdrawn before it is granted, leaves no trace.

Three limits govern a grant, and each one is a cycle count set by a parameter. The first is a minimum distance between any two activations. The second is a cap on how many activations may fall inside a sliding window; the default cap is four. The third is a minimum distance between two activations of the same bank. The number of banks is also a parameter, typically 4 or 8. The scheduler holds a stalled request, with its bank unchanged, until the grant arrives. The earliest legal cycle therefore produces the grant with no extra cycle of latency.

Top module: `act_gate`

## Requirements
- R1: `grant` is high only in a cycle where `req_valid` is high, and it is combinational, so the request is granted in the same cycle it is accepted. With `req_valid` low, `grant` is low.
- R2: While `rst_n` is low, `grant` is low. After reset all limits count as expired, so the first request is granted in the cycle it is presented. A request that follows a long idle period is also granted at once.
- R3: Two grants are never closer than `ACT_GAP` cycles. A request held from the moment that distance is reached is granted exactly `ACT_GAP` cycles after the previous grant.
- R4: Among any `WIN_SLOTS` + 1 consecutive grants, the first and the last are at least `WIN_LEN` cycles apart. An extra request that is stalled only by this rule is granted exactly `WIN_LEN` cycles after the oldest of the last `WIN_SLOTS` grants.
- R5: Two grants to the same bank are at least `ROW_CYCLE` cycles apart. A request stalled only by this rule is granted exactly `ROW_CYCLE` cycles after the previous grant to that bank.
- R6: The row-cycle limit of one bank never delays a request to a different bank.
- R7: A request that is stalled and then withdrawn updates no limit. A later request is timed only from earlier grants.
- R8: `req_bank` is a binary bank index of `$clog2(NUM_BANKS)` bits. Each of the `NUM_BANKS` banks keeps its own row-cycle limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An activate request is pending |
| req_bank | input | $clog2(NUM_BANKS) | Bank index of the pending request |
| grant | output | 1 | The pending activate is issued in this cycle |

## Verification
The bench builds the block with 8 banks, an activation gap of 2 cycles, a window of 10 cycles and a row cycle of 7 cycles. These values make each of the three limits the binding one in turn. With a gap of 2, four back-to-back activations fill only 7 cycles, so the fifth waits on the window and not on the gap. Because the row cycle is shorter than the window, a bank can be released by its own timer while the window still blocks it, which separates the effect of a withdrawn request from the window stall.

// File: rtl/act_gate_pkg.sv
`timescale 1ns/1ps
package act_gate_pkg;

  // Width of every countdown; limits up to 2**CNT_W cycles.
  parameter int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  // Value loaded on a grant so that the timer reads zero exactly GAP cycles later.
  function automatic cnt_t reload_of(input int unsigned gap);
    return cnt_t'(gap - 1);
  endfunction

  // One clock step of a countdown: load on start, else saturating decrement.
  function automatic cnt_t tick(input cnt_t cur, input logic load, input cnt_t reload);
    if (load) return reload;
    if (cur != '0) return cur - 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/act_gap_timer.sv
`timescale 1ns/1ps
module act_gap_timer
  import act_gate_pkg::*;
#(
  parameter int unsigned GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);

  localparam cnt_t RELOAD = reload_of(GAP);

  cnt_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= tick(cnt_q, start, RELOAD);
  end

  assign ready = (cnt_q == '0);

endmodule

// File: rtl/act_faw_window.sv
`timescale 1ns/1ps
module act_faw_window #(
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned WIN_LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic room
);

  logic [SLOTS-1:0] slot_free;
  logic [SLOTS-1:0] slot_pick;

  // Lowest free slot takes the new grant.
  always_comb begin
    logic found;
    found     = 1'b0;
    slot_pick = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_free[i] && !found) begin
        slot_pick[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  assign room = |slot_free;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    act_gap_timer #(.GAP(WIN_LEN)) i_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .start (take && slot_pick[g]),
      .ready (slot_free[g])
    );
  end

endmodule

// File: rtl/act_bank_rc.sv
`timescale 1ns/1ps
module act_bank_rc #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_CYCLE = 7,
  localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] bank,
  output logic          ready
);

  logic [NUM_BANKS-1:0] bank_ready;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    act_gap_timer #(.GAP(ROW_CYCLE)) i_rc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start && (bank == BW'(g))),
      .ready (bank_ready[g])
    );
  end

  assign ready = bank_ready[bank];

endmodule

// File: rtl/act_gate.sv
`timescale 1ns/1ps
module act_gate #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ACT_GAP   = 2,
  parameter int unsigned WIN_LEN   = 10,
  parameter int unsigned WIN_SLOTS = 4,
  parameter int unsigned ROW_CYCLE = 7,
  localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [BW-1:0] req_bank,
  output logic          grant
);

  // Named events for the checker.
  logic gap_ok;
  logic win_ok;
  logic rc_ok;

  act_gap_timer #(.GAP(ACT_GAP)) i_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .start (grant),
    .ready (gap_ok)
  );

  act_faw_window #(.SLOTS(WIN_SLOTS), .WIN_LEN(WIN_LEN)) i_win (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (grant),
    .room  (win_ok)
  );

  act_bank_rc #(.NUM_BANKS(NUM_BANKS), .ROW_CYCLE(ROW_CYCLE)) i_rc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (grant),
    .bank  (req_bank),
    .ready (rc_ok)
  );

  assign grant = rst_n && req_valid && gap_ok && win_ok && rc_ok;

endmodule

// File: rtl/act_gate_chk.sv
`timescale 1ns/1ps
module act_gate_chk #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ACT_GAP   = 2,
  parameter int unsigned WIN_LEN   = 10,
  parameter int unsigned WIN_SLOTS = 4,
  parameter int unsigned ROW_CYCLE = 7,
  localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [BW-1:0] req_bank,
  input logic          grant
);

  logic [31:0]          cyc;
  logic [31:0]          last_t;
  logic                 have_last;
  logic [31:0]          hist [WIN_SLOTS];
  int unsigned          n_hist;
  logic [31:0]          bank_t [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc       <= '0;
      last_t    <= '0;
      have_last <= 1'b0;
      n_hist    <= 0;
      bank_seen <= '0;
      for (int i = 0; i < WIN_SLOTS; i++) hist[i] <= '0;
      for (int i = 0; i < NUM_BANKS; i++) bank_t[i] <= '0;
    end else begin
      cyc <= cyc + 1;
      if (grant) begin
        last_t    <= cyc;
        have_last <= 1'b1;
        hist[0]   <= cyc;
        for (int i = 1; i < WIN_SLOTS; i++) hist[i] <= hist[i-1];
        if (n_hist < WIN_SLOTS) n_hist <= n_hist + 1;
        bank_t[req_bank]    <= cyc;
        bank_seen[req_bank] <= 1'b1;
      end
    end
  end

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> req_valid); // R1

  AST_FIRST_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !have_last) |-> grant); // R2

  AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && have_last) |-> ((cyc - last_t) >= 32'(ACT_GAP))); // R3

  AST_WINDOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && n_hist == WIN_SLOTS) |-> ((cyc - hist[WIN_SLOTS-1]) >= 32'(WIN_LEN))); // R4

  AST_ROW_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && bank_seen[req_bank]) |-> ((cyc - bank_t[req_bank]) >= 32'(ROW_CYCLE))); // R5

endmodule

bind act_gate act_gate_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ACT_GAP   (ACT_GAP),
  .WIN_LEN   (WIN_LEN),
  .WIN_SLOTS (WIN_SLOTS),
  .ROW_CYCLE (ROW_CYCLE)
) i_act_gate_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_bank  (req_bank),
  .grant     (grant)
);

// File: tb/test_act_gate.sv
`timescale 1ns/1ps
module test_act_gate;

  localparam int NB = 8;
  localparam int S  = 2;
  localparam int W  = 10;
  localparam int K  = 4;
  localparam int C  = 7;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [BW-1:0] req_bank = '0;
  logic          grant;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;

  typedef struct { int t; int bank; string tag; } exp_t;
  exp_t exp_q[$];

  // Bench model of the three limits, timestamps of past grants.
  int last_g = -1000;
  int hist [K];
  int bank_last [NB];

  act_gate #(
    .NUM_BANKS (NB), .ACT_GAP (S), .WIN_LEN (W), .WIN_SLOTS (K), .ROW_CYCLE (C)
  ) i_act_gate (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_bank (req_bank), .grant (grant)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int earliest(input int now, input int b);
    int e = now;
    if (last_g + S > e) e = last_g + S;            // R3
    if (hist[K-1] + W > e) e = hist[K-1] + W;      // R4
    if (bank_last[b] + C > e) e = bank_last[b] + C; // R5
    return e;
  endfunction

  function automatic void model_grant(input int t, input int b);
    last_g = t;
    for (int i = K - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = t;
    bank_last[b] = t;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: present a request, push the expected grant, hold until granted.
  task automatic act(input int b, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_bank  = BW'(b);
    e.t = earliest(cyc, b);
    e.bank = b;
    e.tag = tag;
    exp_q.push_back(e);
    model_grant(e.t, b);
    #2;
    while (!grant) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // A request that must stall, withdrawn after one cycle.
  task automatic probe(input int b, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_bank  = BW'(b);
    #2;
    check(grant == 1'b0, tag, int'(grant), 0);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: every grant must match the head of the expected queue.
  always @(negedge clk) begin
    #1;
    if (rst_n && grant) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected grant", cyc, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc == e.t, e.tag, cyc, e.t);
        check(int'(req_bank) == e.bank, e.tag, int'(req_bank), e.bank);
      end
    end
  end

  initial begin
    #250000;
    n_fail++;
    $display("FAIL watchdog expired, pending=%0d expected=0", exp_q.size());
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < K; i++) hist[i] = -1000;
    for (int i = 0; i < NB; i++) bank_last[i] = -1000;

    // R2: no grant while reset is held, even with a request present.
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(grant == 1'b0, "R2 grant during reset", int'(grant), 0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    #2;
    // R1: no request, no grant.
    check(grant == 1'b0, "R1 idle grant", int'(grant), 0);

    act(0, "R2 first request");
    act(1, "R6 other bank after gap");
    act(2, "R3 gap");
    act(3, "R3 gap");
    act(4, "R4 fifth waits window");
    idle(14);
    act(5, "R2 after idle");
    act(5, "R5 same bank");
    act(6, "R6 other bank not held");
    idle(14);

    // R7: burst of four, window-stalled probe to bank 1, then bank 1 again.
    act(1, "R7 setup");
    act(2, "R7 setup");
    act(3, "R7 setup");
    act(4, "R7 setup");
    idle(1);
    probe(1, "R7 stalled probe");
    act(1, "R7 withdrawn stall left no history");
    idle(14);

    // R8: stream across all banks, each bank timed on its own.
    for (int i = 0; i < 16; i++) act(i % NB, "R8 bank stream");
    act(7, "R5 repeat last bank");
    for (int i = 0; i < 6; i++) act((i % 2) * 3, "R5 two-bank ping-pong");

    idle(4);
    check(exp_q.size() == 0, "R1 all grants seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule